// File: doc/BRIEF.md
# Packed Dual-Entry Colour Palette

This block holds a colour palette of 256 entries in 128 storage words of 32 bits, two 16-bit entries sharing each word. A register port writes and reads whole raw words, so a single write always replaces the pair of entries that the word covers. A lookup port takes an 8-bit entry index and, one cycle later, returns a 24-bit colour. Each 16-bit entry packs three 5-bit components plus an intensity bit that plays no part in the result. Each component is widened to 8 bits by appending three zero bits.

The lookup side is a stream. A request is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. The colour then appears on `col_data` with `col_valid` high on the following cycle. A stalled consumer (`col_ready` low) holds the colour and its valid flag steady, and `lk_ready` drops so that no new request is taken. `lk_ready` is high whenever the output register is empty or is being drained in the same cycle. The register port is plain: a read request returns its data one cycle later and needs no handshake. The channel-order flag `lk_bgr` is sampled together with the request it accompanies.

Top module: `palette_lut`

## Requirements
- R1: After reset every word reads as zero, and `col_valid` is low.
- R2: A write with `reg_offset[9]` set stores `reg_wdata` in word `reg_offset[8:2]`, and `reg_offset[1:0]` is ignored. A read with `reg_offset[9]` set returns that word unchanged on `reg_rdata` in the next cycle. `reg_rdata` is left unchanged in cycles with no read.
- R3: Offsets with `reg_offset[9]` clear fall outside the palette. A write there changes no word, and a read there returns zero.
- R4: Entry 2n is taken from bits 15:0 of word n, and entry 2n+1 from bits 31:16. The entry index is `lk_index`, with the word in `lk_index[7:1]` and the half chosen by `lk_index[0]`.
- R5: Within an entry, bits 4:0 hold red, bits 9:5 hold green and bits 14:10 hold blue. Bit 15 is ignored. Each 5-bit component appears as the upper five bits of its 8-bit output channel, and the low three bits of each channel are zero.
- R6: With `lk_bgr` high, `col_data[7:0]` carries red, `[15:8]` green and `[23:16]` blue. With `lk_bgr` low, the red and blue channels trade places.
- R7: A request accepted on an edge produces `col_valid` high and its colour on `col_data` after exactly that edge.
- R8: While `col_valid` is high and `col_ready` is low, `col_data` and `col_valid` stay stable and `lk_ready` is low. `lk_ready` is high whenever `col_valid` is low.
- R9: A lookup accepted in the same cycle as a write to its word returns the newly written value.
- R10: One word write changes the colours of both entries that the word covers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Word write strobe |
| reg_rd_en | input | 1 | Word read strobe |
| reg_offset | input | 10 | Byte offset; bit 9 selects the palette window |
| reg_wdata | input | 32 | Raw word to write |
| reg_rdata | output | 32 | Raw word read, one cycle after the strobe |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with valid |
| lk_index | input | 8 | Entry index of the request |
| lk_bgr | input | 1 | Channel order for the request |
| col_valid | output | 1 | Colour output valid |
| col_ready | input | 1 | Consumer ready for the colour |
| col_data | output | 24 | Expanded colour |

## Verification
The hardest case to reach from the ports is a lookup accepted on the same edge as a write to the word it reads. The array still holds the old value then, so only the forwarding path can supply the right colour. The stimulus drives a write strobe and a lookup request in the same cycle, for both halves of a word. A second hard case is a request waiting at the input while the output is stalled. The stimulus holds `col_ready` low for several cycles with a different request pending, then releases it. It checks that the held colour never changes and that the pending request is served on the first edge after the release.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int COMP_W = 5;
  localparam int CHAN_W = 8;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PAD_W  = CHAN_W - COMP_W;
  localparam int COL_W  = 3 * CHAN_W;

  typedef struct packed {
    logic [CHAN_W-1:0] hi;
    logic [CHAN_W-1:0] mid;
    logic [CHAN_W-1:0] lo;
  } colour_t;

  // widen a packed entry to three 8-bit channels; bit 15 takes no part
  function automatic colour_t widen_entry(input logic [HALF_W-1:0] ent,
                                          input logic               red_low);
    colour_t c;
    logic [CHAN_W-1:0] red, grn, blu;
    red = {ent[COMP_W-1:0],            {PAD_W{1'b0}}};
    grn = {ent[2*COMP_W-1:COMP_W],     {PAD_W{1'b0}}};
    blu = {ent[3*COMP_W-1:2*COMP_W],   {PAD_W{1'b0}}};
    c.mid = grn;
    if (red_low) begin
      c.lo = red;
      c.hi = blu;
    end else begin
      c.lo = blu;
      c.hi = red;
    end
    return c;
  endfunction

endpackage

// File: rtl/pal_store.sv
module pal_store #(
  parameter int WA_W = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [WA_W-1:0]           waddr,
  input  logic [pal_pkg::WORD_W-1:0] wdata,
  input  logic [WA_W-1:0]           raddr_reg,
  output logic [pal_pkg::WORD_W-1:0] rdata_reg,
  input  logic [WA_W-1:0]           raddr_lk,
  output logic [pal_pkg::WORD_W-1:0] rdata_lk
);
  localparam int WORDS = 1 << WA_W;

  logic [pal_pkg::WORD_W-1:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else if (we && (waddr == WA_W'(w))) begin
        word_q[w] <= wdata;
      end
    end
  end

  assign rdata_reg = word_q[raddr_reg];
  assign rdata_lk  = word_q[raddr_lk];

endmodule

// File: rtl/pal_entry_pick.sv
module pal_entry_pick (
  input  logic [pal_pkg::WORD_W-1:0] stored_word,
  input  logic                       wr_hit,
  input  logic [pal_pkg::WORD_W-1:0] wr_word,
  input  logic                       upper_half,
  output logic [pal_pkg::HALF_W-1:0] entry
);
  localparam int HW = pal_pkg::HALF_W;

  logic [pal_pkg::WORD_W-1:0] live_word;

  // write-first: a same-cycle write to this word wins over the array
  always_comb begin
    live_word = wr_hit ? wr_word : stored_word;
    entry     = upper_half ? live_word[2*HW-1:HW] : live_word[HW-1:0];
  end

endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;
  logic         take;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (take) begin
      dat_q <= in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [IDX_W+1:0]   reg_offset,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [IDX_W-1:0]   lk_index,
  input  logic               lk_bgr,
  output logic               col_valid,
  input  logic               col_ready,
  output logic [23:0]        col_data
);
  import pal_pkg::*;

  localparam int WA_W  = IDX_W - 1;
  localparam int OFF_W = IDX_W + 2;
  localparam int WIN_B = OFF_W - 1;

  logic              in_window;
  logic [WA_W-1:0]   reg_word;
  logic              wr_go;
  logic [WORD_W-1:0] store_reg_word;
  logic [WORD_W-1:0] store_lk_word;
  logic [WA_W-1:0]   lk_word;
  logic              wr_hit;
  logic [HALF_W-1:0] entry;
  colour_t           colour;
  logic [WORD_W-1:0] rdata_q;
  logic [1:0]        unused_byte_sel;

  assign in_window       = reg_offset[WIN_B];
  assign reg_word        = reg_offset[WIN_B-1:2];
  assign unused_byte_sel = reg_offset[1:0];
  assign wr_go           = reg_wr_en && in_window;
  assign lk_word         = lk_index[IDX_W-1:1];
  assign wr_hit          = wr_go && (reg_word == lk_word);

  pal_store #(.WA_W(WA_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_go),
    .waddr     (reg_word),
    .wdata     (reg_wdata),
    .raddr_reg (reg_word),
    .rdata_reg (store_reg_word),
    .raddr_lk  (lk_word),
    .rdata_lk  (store_lk_word)
  );

  pal_entry_pick pick_i (
    .stored_word (store_lk_word),
    .wr_hit      (wr_hit),
    .wr_word     (reg_wdata),
    .upper_half  (lk_index[0]),
    .entry       (entry)
  );

  assign colour = widen_entry(entry, lk_bgr);

  pal_out_stage #(.W(COL_W)) out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lk_valid),
    .in_ready  (lk_ready),
    .in_data   (colour),
    .out_valid (col_valid),
    .out_ready (col_ready),
    .out_data  (col_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      rdata_q <= in_window ? store_reg_word : '0;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/palette_lut_checker.sv
module palette_lut_checker #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic             reg_rd_en,
  input logic [IDX_W+1:0] reg_offset,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [IDX_W-1:0] lk_index,
  input logic             lk_bgr,
  input logic             col_valid,
  input logic             col_ready,
  input logic [23:0]      col_data
);
  localparam int WIN_B = IDX_W + 1;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata)); // R2

  AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en && !reg_offset[WIN_B] |=> reg_rdata == 32'd0); // R3

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (col_data[2:0] == 3'd0) && (col_data[10:8] == 3'd0)
                  && (col_data[18:16] == 3'd0)); // R5

  AST_ACCEPT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> col_valid); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready |=> col_valid && $stable(col_data)); // R8

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> lk_ready); // R8

  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready |-> !lk_ready); // R8

  AST_FORWARD_RED: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready && lk_bgr && reg_wr_en && reg_offset[WIN_B]
      && (reg_offset[WIN_B-1:2] == lk_index[IDX_W-1:1])
    |=> col_data[7:3] == $past(lk_index[0] ? reg_wdata[20:16] : reg_wdata[4:0])); // R9

endmodule

bind palette_lut palette_lut_checker #(.IDX_W(IDX_W)) chk_i (.*);

// File: tb/palette_lut_tb_top.sv
module palette_lut_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [9:0]  reg_offset = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [7:0]  lk_index = '0;
  logic        lk_bgr = 1'b1;
  logic        col_valid;
  logic        col_ready = 1'b1;
  logic [23:0] col_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [128];

  always #2 clk = ~clk;

  palette_lut dut_i (.*);

  function automatic logic [23:0] exp_col(input logic [31:0] w, input logic up,
                                          input logic bgr);
    logic [15:0] h;
    logic [7:0] r, g, b;
    h = up ? w[31:16] : w[15:0];
    r = {h[4:0], 3'b000};
    g = {h[9:5], 3'b000};
    b = {h[14:10], 3'b000};
    return bgr ? {b, g, r} : {r, g, b};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_offset = off; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (off[9]) model[off[8:2]] = d;
  endtask

  task automatic rd(input logic [9:0] off, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_offset = off;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic look(input logic [7:0] idx, input logic bgr, output logic [23:0] c);
    @(negedge clk);
    lk_valid = 1'b1; lk_index = idx; lk_bgr = bgr;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R7 valid", {31'd0, col_valid}, 32'd1);
    c = col_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int bad = 0;
    check("R1 col_valid", {31'd0, col_valid}, 32'd0);
    for (int i = 0; i < 128; i++) begin
      rd(10'h200 + 10'(i * 4), d);
      if (d !== 32'd0) bad++;
    end
    check("R1 zero words", bad, 0);
  endtask

  task automatic t_raw_rw();
    logic [31:0] d;
    logic [31:0] q;
    wr(10'h204, 32'hDEAD_BEEF);
    rd(10'h204, d);
    check("R2 raw read", d, 32'hDEAD_BEEF);
    wr(10'h3FF, 32'h1234_5678);
    rd(10'h3FC, d);
    check("R2 byte bits ignored", d, 32'h1234_5678);
    q = reg_rdata;
    repeat (3) @(negedge clk);
    check("R2 rdata held", reg_rdata, q);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(10'h100, 32'hCAFE_F00D);
    rd(10'h300, d);
    check("R3 outside write ignored", d, model[64]);
    rd(10'h100, d);
    check("R3 outside read zero", d, 32'd0);
  endtask

  task automatic t_halves();
    logic [23:0] c;
    wr(10'h208, 32'h7C1F_83E0);
    look(8'd4, 1'b1, c);
    check("R4 low half", {8'd0, c}, {8'd0, exp_col(model[2], 1'b0, 1'b1)});
    look(8'd5, 1'b1, c);
    check("R4 high half", {8'd0, c}, {8'd0, exp_col(model[2], 1'b1, 1'b1)});
    wr(10'h20C, 32'hFFFF_8421);
    look(8'd6, 1'b1, c);
    check("R5 expand, intensity ignored", {8'd0, c}, 32'h0008_0808);
    look(8'd7, 1'b1, c);
    check("R5 full scale", {8'd0, c}, 32'h00F8_F8F8);
  endtask

  task automatic t_bgr();
    logic [23:0] c;
    wr(10'h210, 32'h0000_0C1F);
    look(8'd8, 1'b1, c);
    check("R6 bgr high", {8'd0, c}, 32'h0018_00F8);
    look(8'd8, 1'b0, c);
    check("R6 bgr low", {8'd0, c}, 32'h00F8_0018);
  endtask

  task automatic t_both_entries();
    logic [23:0] c;
    wr(10'h214, 32'h2A55_1234);
    look(8'd10, 1'b0, c);
    check("R10 entry 2n", {8'd0, c}, {8'd0, exp_col(model[5], 1'b0, 1'b0)});
    look(8'd11, 1'b0, c);
    check("R10 entry 2n+1", {8'd0, c}, {8'd0, exp_col(model[5], 1'b1, 1'b0)});
  endtask

  task automatic t_forward();
    @(negedge clk);
    reg_wr_en = 1'b1; reg_offset = 10'h218; reg_wdata = 32'h03E0_7C00;
    lk_valid = 1'b1; lk_index = 8'd13; lk_bgr = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; model[6] = 32'h03E0_7C00;
    check("R9 forward high", {8'd0, col_data}, {8'd0, exp_col(model[6], 1'b1, 1'b1)});
    reg_wr_en = 1'b1; reg_offset = 10'h218; reg_wdata = 32'h0000_001F;
    lk_index = 8'd12;
    @(negedge clk);
    reg_wr_en = 1'b0; lk_valid = 1'b0; model[6] = 32'h0000_001F;
    check("R9 forward low", {8'd0, col_data}, {8'd0, exp_col(model[6], 1'b0, 1'b1)});
  endtask

  task automatic t_stall();
    logic [23:0] a;
    @(negedge clk);
    col_ready = 1'b0;
    lk_valid = 1'b1; lk_index = 8'd4; lk_bgr = 1'b0;
    @(negedge clk);
    a = col_data;
    check("R7 first", {8'd0, a}, {8'd0, exp_col(model[2], 1'b0, 1'b0)});
    lk_index = 8'd13; lk_bgr = 1'b1;
    check("R8 not ready", {31'd0, lk_ready}, 32'd0);
    repeat (3) @(negedge clk);
    check("R8 held data", {8'd0, col_data}, {8'd0, a});
    check("R8 held valid", {31'd0, col_valid}, 32'd1);
    col_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R8 pending served", {8'd0, col_data}, {8'd0, exp_col(model[6], 1'b1, 1'b1)});
    @(negedge clk);
    check("R8 drained", {31'd0, col_valid}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_raw_rw();
    t_window();
    t_halves();
    t_bgr();
    t_both_entries();
    t_forward();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule